// File: doc/BRIEF.md
# Interrupt Status and Mask Block

This block gathers the event sources of a serial bus master into one sticky status register, holds a mask register of the same layout, and drives a single interrupt line. Six sources are pulse events that latch into the status register. The two data-request sources reflect the live transmit and receive FIFO level conditions. Software reads the status register, clears latched bits by writing ones to them, and enables sources by loading the mask.

The bit layout of status and mask is fixed, because event generators and software both decode it. Bit 7 is packet done. Bit 6 is all packets done. Bit 5 is transmit overflow. Bit 4 is receive underflow. Bit 3 is missing acknowledge. Bit 2 is lost arbitration. Bit 1 is transmit data request and bit 0 is receive data request. Packet done raises the interrupt line even when its mask bit is clear. Missing acknowledge and lost arbitration are error sources, and either one raises a transfer-abort output.

Top module: `intr_status_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, status, mask, irq and xfer_abort are all zero. Every maskable source therefore starts disabled.
- R2: A 1 on evt_in[k] at a rising edge sets status bit k+2 at that edge. The bit then stays set until a clear write removes it.
- R3: A write with wr_en=1 and wr_sel=0 clears every status bit 7..2 whose wr_data bit is 1. Bits whose wr_data bit is 0 keep their value.
- R4: When an event and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R5: Status bits 1 (transmit request) and 0 (receive request) take the value of lvl_in[1] and lvl_in[0] at each rising edge. A clear write does not change them.
- R6: A write with wr_en=1 and wr_sel=1 loads all eight bits of wr_data into the mask, which appears on mask after that edge. A 1 in a mask bit enables that source.
- R7: irq is high exactly when some status bit is set together with its mask bit, or when status bit 7 (packet done) is set, whatever mask bit 7 holds.
- R8: xfer_abort is high exactly when status bit 3 (missing acknowledge) or status bit 2 (lost arbitration) is set.
- R9: A mask write leaves the status register unchanged, and a status clear write leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 6 | Event pulses; evt_in[k] sets status bit k+2 |
| lvl_in | input | 2 | Live request levels: [1] transmit, [0] receive |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 clears status by ones, 1 loads mask |
| wr_data | input | 8 | Write data |
| status | output | 8 | Status register |
| mask | output | 8 | Mask register |
| irq | output | 1 | Interrupt line |
| xfer_abort | output | 1 | An error source is pending |

## Verification
Status and mask change at the rising edge that samples the event, level or write. irq and xfer_abort follow the registers combinationally, so they settle in that same cycle. The bench drives inputs on the falling edge and advances its own register model at the next rising edge. It compares every output a quarter period after that edge, so each result is checked in the first cycle it is due.

// File: rtl/intr_status_ctrl.sv
module intr_status_ctrl #(
  parameter int NBITS    = 8,
  parameter int LVL_BITS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NBITS-LVL_BITS-1:0] evt_in,
  input  logic [LVL_BITS-1:0]       lvl_in,
  input  logic                      wr_en,
  input  logic                      wr_sel,
  input  logic [NBITS-1:0]          wr_data,
  output logic [NBITS-1:0]          status,
  output logic [NBITS-1:0]          mask,
  output logic                      irq,
  output logic                      xfer_abort
);
  localparam int EVT_BITS = NBITS - LVL_BITS;
  localparam int PKT_DONE = NBITS - 1;
  localparam int ERR_NAK  = LVL_BITS + 1;
  localparam int ERR_ARB  = LVL_BITS;

  logic [NBITS-1:0]    st_q, mk_q;
  logic [EVT_BITS-1:0] clr;

  assign clr = (wr_en && !wr_sel) ? wr_data[NBITS-1:LVL_BITS] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      mk_q <= '0;
    end else begin
      st_q[NBITS-1:LVL_BITS] <= (st_q[NBITS-1:LVL_BITS] & ~clr) | evt_in;
      st_q[LVL_BITS-1:0]     <= lvl_in;
      if (wr_en && wr_sel) mk_q <= wr_data;
    end
  end

  assign status     = st_q;
  assign mask       = mk_q;
  assign irq        = (|(st_q & mk_q)) | st_q[PKT_DONE];
  assign xfer_abort = st_q[ERR_NAK] | st_q[ERR_ARB];
endmodule

module intr_status_ctrl_chk #(
  parameter int NBITS    = 8,
  parameter int LVL_BITS = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NBITS-LVL_BITS-1:0] evt_in,
  input logic [LVL_BITS-1:0]       lvl_in,
  input logic                      wr_en,
  input logic                      wr_sel,
  input logic [NBITS-1:0]          wr_data,
  input logic [NBITS-1:0]          status,
  input logic [NBITS-1:0]          mask,
  input logic                      irq,
  input logic                      xfer_abort
);
  localparam int EVT_BITS = NBITS - LVL_BITS;

  logic [EVT_BITS-1:0] keep;
  assign keep = status[NBITS-1:LVL_BITS] &
                ~(wr_data[NBITS-1:LVL_BITS] & {EVT_BITS{wr_en && !wr_sel}});

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status[NBITS-1:LVL_BITS] & $past(keep)) == $past(keep)));

  // R4
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status[NBITS-1:LVL_BITS] & $past(evt_in)) == $past(evt_in)));

  // R5
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status[LVL_BITS-1:0] == $past(lvl_in)));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (mask == $past(wr_data)));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> $stable(mask));

  // R7
  pkt_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[NBITS-1] |-> irq);

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & mask) == '0 && !status[NBITS-1]) |-> !irq);

  // R8
  abort_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[LVL_BITS+1] || status[LVL_BITS]) |-> xfer_abort);
endmodule

bind intr_status_ctrl intr_status_ctrl_chk #(.NBITS(NBITS), .LVL_BITS(LVL_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .lvl_in(lvl_in),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .status(status), .mask(mask), .irq(irq), .xfer_abort(xfer_abort)
);

// File: tb/intr_status_ctrl_bench.sv
module intr_status_ctrl_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] evt_in = '0;
  logic [1:0] lvl_in = '0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] status, mask;
  logic       irq, xfer_abort;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_st = '0;
  logic [7:0] m_mk = '0;

  always #(PERIOD/2) clk = ~clk;

  intr_status_ctrl u_intr_status_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .lvl_in(lvl_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .status(status), .mask(mask), .irq(irq), .xfer_abort(xfer_abort)
  );

  function automatic logic [7:0] nxt_st(logic [7:0] st, logic [5:0] ev, logic [1:0] lv,
                                        logic we, logic sel, logic [7:0] d);
    logic [5:0] c = (we && !sel) ? d[7:2] : 6'h0;
    return {(st[7:2] & ~c) | ev, lv};
  endfunction

  function automatic logic exp_irq(logic [7:0] st, logic [7:0] mk);
    return (|(st & mk)) | st[7];
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tst, string tmk);
    chk(tst, status, m_st);
    chk(tmk, mask, m_mk);
    chk("R7 irq", {7'h0, irq}, {7'h0, exp_irq(m_st, m_mk)});
    chk("R8 abort", {7'h0, xfer_abort}, {7'h0, m_st[3] | m_st[2]});
  endtask

  task automatic step(logic [5:0] ev, logic [1:0] lv, logic we, logic sel, logic [7:0] d,
                      string tst, string tmk);
    @(negedge clk);
    evt_in = ev; lvl_in = lv; wr_en = we; wr_sel = sel; wr_data = d;
    @(posedge clk);
    m_st = nxt_st(m_st, ev, lv, we, sel, d);
    if (we && sel) m_mk = d;
    #(PERIOD/4);
    check_all(tst, tmk);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5C));
    lvl_in = 2'b11; evt_in = 6'h3F;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    check_all("R1 status in reset", "R1 mask in reset");
    @(negedge clk);
    evt_in = '0; lvl_in = '0;
    rst_n = 1'b1;
    @(posedge clk);
    #(PERIOD/4);
    check_all("R1 status after reset", "R1 mask after reset");

    // R7: packet done with a zero mask still raises irq
    step(6'b100000, 2'b00, 1'b0, 1'b0, 8'h00, "R2 pkt set", "R9 mask");
    chk("R7 pkt unmasked", {7'h0, irq}, 8'h01);
    step(6'h00, 2'b00, 1'b1, 1'b0, 8'h80, "R3 clear pkt", "R9 mask");
    chk("R7 irq low", {7'h0, irq}, 8'h00);
    // R8: missing acknowledge pending
    step(6'b000010, 2'b00, 1'b0, 1'b0, 8'h00, "R2 nak set", "R9 mask");
    chk("R8 abort nak", {7'h0, xfer_abort}, 8'h01);
    chk("R7 nak masked", {7'h0, irq}, 8'h00);
    // R9: mask write leaves status
    step(6'h00, 2'b00, 1'b1, 1'b1, 8'h08, "R9 status kept", "R6 mask load");
    chk("R7 nak enabled", {7'h0, irq}, 8'h01);
    // R4: event and clear on the same bit
    step(6'b000010, 2'b00, 1'b1, 1'b0, 8'h08, "R4 set wins", "R9 mask kept");
    // R3: zero bits keep their value
    step(6'b000101, 2'b00, 1'b1, 1'b0, 8'h04, "R3 partial clear", "R9 mask kept");
    // R5: level bits follow input, clear has no effect
    step(6'h00, 2'b11, 1'b0, 1'b0, 8'h00, "R5 level rise", "R9 mask");
    step(6'h00, 2'b11, 1'b1, 1'b0, 8'h03, "R5 clear ignored", "R9 mask");
    step(6'h00, 2'b01, 1'b0, 1'b0, 8'h00, "R5 level fall", "R9 mask");
    step(6'h00, 2'b00, 1'b1, 1'b0, 8'hFC, "R3 clear all", "R9 mask");
    chk("R8 abort cleared", {7'h0, xfer_abort}, 8'h00);

    for (int i = 0; i < 600; i++) begin
      logic [5:0] ev = ($urandom % 4 == 0) ? 6'($urandom) : 6'h00;
      logic we = ($urandom % 3 == 0);
      step(ev, 2'($urandom), we, 1'($urandom), 8'($urandom), "R2 R3 random status", "R6 random mask");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule